// File: doc/BRIEF.md
# Host Interface Request Generator

This block is the host-side control logic of a parallel port between a host processor and a DSP. The host writes a small control register. That register holds enables for transmit and receive requests, a select bit for split request pins, and two general-purpose flags. From those fields, the transfer mode and the transmit-empty and receive-full status, the block drives two active-low request pins. The host flags are also carried across to the DSP clock domain as read-only status bits.

When the split select bit is clear, pin A is one combined request. Pin B is released so that it can serve as an acknowledge input, and its output enable is low. When the split select bit is set, pin A carries the transmit request and pin B carries the receive request.

In interrupt mode the requests mean "service me". In DMA mode they request data movement in one direction, and setting both enables is a reserved combination that produces no request.

Top module: `host_req_gen`

## Requirements
- R1: After reset:
  - `hst_rdata` reads 0.
  - `req_a_n` and `req_b_n` are 1.
  - `req_b_oe` is 0.
  - `dsp_flags` is 0.
- R2: On a clock with `hst_wr` high, the control register loads `hst_wdata`. Without a write it holds its value. `hst_rdata` shows the register at all times. The field layout is:
  - bit 0: receive-request enable.
  - bit 1: transmit-request enable.
  - bit 2: split select.
  - bit 3: host flag 0.
  - bit 4: host flag 1.
- R3: With split select 0 and `xfer_mode` = 00 (interrupt mode), one clock later:
  - `req_a_n` is low exactly when (receive enable and `rx_full`) or (transmit enable and `tx_empty`).
  - `req_b_n` is 1 and `req_b_oe` is 0.
- R4: With split select 1, one clock later:
  - `req_a_n` is low exactly when transmit enable and `tx_empty` are both set.
  - `req_b_n` is low exactly when receive enable and `rx_full` are both set.
  - `req_b_oe` is 1.
- R5: When `xfer_mode` is nonzero (DMA mode), requests follow R3 and R4 for a single enable. If both enables are set, both request pins stay high one clock later.
- R6: Host flags 0 and 1 appear on `dsp_flags[0]` and `dsp_flags[1]` after a two-stage synchronizer in the `dsp_clk` domain. They change only through host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Host-side asynchronous reset, active low |
| hst_wr | input | 1 | Control register write strobe |
| hst_wdata | input | 5 | Control register write data |
| hst_rdata | output | 5 | Control register read data |
| xfer_mode | input | 2 | 00 interrupt mode, nonzero DMA mode |
| tx_empty | input | 1 | Transmit data register empty |
| rx_full | input | 1 | Receive data register full |
| req_a_n | output | 1 | Combined or transmit request, active low |
| req_b_n | output | 1 | Receive request, active low |
| req_b_oe | output | 1 | Pin B output enable (0: acknowledge input) |
| dsp_clk | input | 1 | DSP-side clock |
| dsp_rst_n | input | 1 | DSP-side asynchronous reset, active low |
| dsp_flags | output | 2 | Synchronized host flags for the DSP status register |

## Verification
Random control writes, modes and status bits walk through all combinations of split select, both enables and both status bits in both modes. This separates the combined-pin OR from the split-pin routing, and shows that each enable gates only its own status bit. Directed cases set both enables in DMA mode with both status bits active. That isolates the reserved suppression from plain interrupt behaviour, which would assert the request. Flag writes with 0/1 patterns show that each flag reaches its own DSP-side bit after synchronization and that status activity does not disturb it.

// File: rtl/host_req_gen.sv
module host_req_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_wr,
  input  logic [4:0] hst_wdata,
  output logic [4:0] hst_rdata,
  input  logic [1:0] xfer_mode,
  input  logic       tx_empty,
  input  logic       rx_full,
  output logic       req_a_n,
  output logic       req_b_n,
  output logic       req_b_oe,
  input  logic       dsp_clk,
  input  logic       dsp_rst_n,
  output logic [1:0] dsp_flags
);
  localparam int RXE = 0;
  localparam int TXE = 1;
  localparam int SPL = 2;
  localparam int FL0 = 3;
  localparam int FL1 = 4;

  logic [4:0] ctrl;
  logic       reserved, tx_rq, rx_rq;
  logic [SYNC_STAGES-1:0][1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (hst_wr) ctrl <= hst_wdata;

  assign hst_rdata = ctrl;
  assign reserved  = (|xfer_mode) & ctrl[RXE] & ctrl[TXE];
  assign tx_rq     = ctrl[TXE] & tx_empty & ~reserved;
  assign rx_rq     = ctrl[RXE] & rx_full & ~reserved;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_a_n  <= 1'b1;
      req_b_n  <= 1'b1;
      req_b_oe <= 1'b0;
    end else begin
      req_a_n  <= ~(ctrl[SPL] ? tx_rq : (tx_rq | rx_rq));
      req_b_n  <= ~(ctrl[SPL] & rx_rq);
      req_b_oe <= ctrl[SPL];
    end

  always_ff @(posedge dsp_clk or negedge dsp_rst_n)
    if (!dsp_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], {ctrl[FL1], ctrl[FL0]}};

  assign dsp_flags = sync_q[SYNC_STAGES-1];
endmodule

module host_req_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hst_wr,
  input logic [4:0] hst_wdata,
  input logic [4:0] hst_rdata,
  input logic [1:0] xfer_mode,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       req_a_n,
  input logic       req_b_n,
  input logic       req_b_oe
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_wr |=> $stable(hst_rdata));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr |=> hst_rdata == $past(hst_wdata));

  a_r3_combined: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_rdata[2] && xfer_mode == 2'b00) |=>
      (req_a_n == !$past((hst_rdata[0] && rx_full) || (hst_rdata[1] && tx_empty)))
      && req_b_n && !req_b_oe);

  a_r4_split: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rdata[2] && !(xfer_mode != 2'b00 && hst_rdata[1:0] == 2'b11)) |=>
      (req_a_n == !$past(hst_rdata[1] && tx_empty))
      && (req_b_n == !$past(hst_rdata[0] && rx_full)) && req_b_oe);

  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_mode != 2'b00 && hst_rdata[1:0] == 2'b11) |=> (req_a_n && req_b_n));
endmodule

bind host_req_gen host_req_gen_chk u_chk (.*);

// File: tb/host_req_gen_bench.sv
module host_req_gen_bench;
  logic clk = 0, dsp_clk = 0, rst_n = 0, dsp_rst_n = 0;
  logic hst_wr = 0, tx_empty = 0, rx_full = 0;
  logic [4:0] hst_wdata = '0;
  logic [1:0] xfer_mode = '0;
  logic [4:0] hst_rdata;
  logic req_a_n, req_b_n, req_b_oe;
  logic [1:0] dsp_flags;
  int checks = 0, fails = 0;
  logic [4:0] m_ctrl = '0;

  always #2 clk = ~clk;
  always #3.5 dsp_clk = ~dsp_clk;

  host_req_gen u_host_req_gen (.*);

  function automatic logic [2:0] exp_pins(logic [4:0] c, logic [1:0] m, logic te, logic rf);
    logic rsv, t, r;
    rsv = (m != 0) && c[0] && c[1];
    t = c[1] && te && !rsv;
    r = c[0] && rf && !rsv;
    if (c[2]) return {!t, !r, 1'b1};
    return {!(t || r), 1'b1, 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [4:0] wd, logic [1:0] md, logic te, logic rf);
    logic [2:0] e;
    string tag;
    hst_wr = wr; hst_wdata = wd; xfer_mode = md; tx_empty = te; rx_full = rf;
    @(posedge clk); @(negedge clk);
    e = exp_pins(m_ctrl, md, te, rf);
    tag = m_ctrl[2] ? "R4" : (md != 0 ? "R5" : "R3");
    if (md != 0 && m_ctrl[1:0] == 2'b11) tag = "R5 reserved";
    chk(tag, {5'b0, req_a_n, req_b_n, req_b_oe}, {5'b0, e});
    if (wr) m_ctrl = wd;
    chk("R2", {3'b0, hst_rdata}, {3'b0, m_ctrl});
  endtask

  task automatic flags_check(logic [1:0] f);
    step(1'b1, {f, 3'b000}, 2'b00, 1'b1, 1'b1);
    repeat (2) step(1'b0, 5'b0, 2'b01, 1'b1, 1'b0);
    repeat (4) @(posedge dsp_clk);
    #1;
    chk("R6", {6'b0, dsp_flags}, {6'b0, f});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", {3'b0, hst_rdata}, 8'h00);
    chk("R1", {5'b0, req_a_n, req_b_n, req_b_oe}, 8'h06);
    chk("R1", {6'b0, dsp_flags}, 8'h00);
    rst_n = 1; dsp_rst_n = 1;
    @(negedge clk);

    step(1'b1, 5'b00011, 2'b00, 1'b0, 1'b0);
    step(1'b0, 5'b0, 2'b00, 1'b1, 1'b1);
    step(1'b0, 5'b0, 2'b10, 1'b1, 1'b1);
    step(1'b1, 5'b00111, 2'b11, 1'b1, 1'b1);
    step(1'b0, 5'b0, 2'b01, 1'b1, 1'b1);
    step(1'b0, 5'b0, 2'b00, 1'b1, 1'b1);
    step(1'b1, 5'b00001, 2'b01, 1'b1, 1'b1);
    step(1'b0, 5'b0, 2'b01, 1'b0, 1'b1);

    flags_check(2'b01);
    flags_check(2'b10);
    flags_check(2'b11);
    flags_check(2'b00);

    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) == 0, 5'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule